// File: doc/BRIEF.md
# Line Fill Burst Order Generator

When a cache line is refilled after a miss, the words of the line are fetched one per beat. This block works out which word offset each beat should carry. A requester pulses a start strobe with the offset of the word that missed and an order code. The block then presents one offset per beat and moves to the next offset on each next-beat strobe. It raises a last-beat flag on the final word of the line. Memory access and data movement belong to the surrounding logic.

Three orders are offered. The sequential order always begins at word 0, so the missed word arrives at whatever position it holds in the line. The wrapping order delivers the missed word first, counts up to the end of the line and then continues from word 0. The paired order also delivers the missed word first, then its partner in the same aligned two-word pair, and only after that moves on to other pairs. This suits memories that are twice as wide as a word. The line length is a parameter and must be a power of two, at least 2.

Top module: `burst_order_gen`

## Requirements
- R1: After an asynchronous active-low reset, beatValid and lastBeat are 0 and beatOfs is 0.
- R2: A startPulse while no burst is active starts a burst: in the next cycle beatValid is 1 and beatOfs carries the first offset of the selected order.
- R3: Order code 2'b00 (sequential) gives offsets 0, 1, ..., LINE_WORDS-1 for any critical offset.
- R4: Order code 2'b01 (wrapping) gives offset (crit + k) mod LINE_WORDS on beat k, so crit 1 on a 4-word line gives 1, 2, 3, 0.
- R5: Order code 2'b10 (paired) gives offset crit XOR k on beat k, so crit 1 gives 1, 0, 3, 2. Beat 1 is always the partner word of the same aligned pair.
- R6: Order code 2'b11 is reserved and behaves as the sequential order.
- R7: While a burst is active and nextBeat is low, beatOfs and beatValid hold their values.
- R8: lastBeat is 1 exactly on beat LINE_WORDS-1 of a burst. A nextBeat on that beat returns the block to idle in the next cycle.
- R9: While idle, beatOfs is 0, lastBeat is 0, and nextBeat has no effect: beatValid stays 0.
- R10: A startPulse during an active burst is ignored. The critical offset and order code are sampled only at the accepted start, so later changes on those inputs do not alter the running burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Request to begin a new burst |
| critOfs | input | $clog2(LINE_WORDS) | Word offset of the missed word, sampled at start |
| orderSel | input | 2 | Order code: 00 sequential, 01 wrapping, 10 paired, 11 as 00 |
| nextBeat | input | 1 | Advance to the next beat of the active burst |
| beatOfs | output | $clog2(LINE_WORDS) | Word offset for the current beat; 0 when idle |
| beatValid | output | 1 | A burst is active and beatOfs is meaningful |
| lastBeat | output | 1 | The current beat is the final word of the line |

## Verification
The properties assume that the inputs are stable around the rising clock edge and that orderSel and critOfs carry defined values whenever startPulse is high. They place no limit on when startPulse or nextBeat may arrive. Because of this, they also cover strobes that reach the block while it is idle, and starts that arrive in the middle of a burst. The stimulus changes every input only on the falling edge and always drives a legal offset and order code together with each start. It also deliberately sends starts, order changes and next-beat strobes at moments when they must be ignored.

// File: rtl/burst_order_pkg.sv
package burst_order_pkg;

  // Order codes seen on orderSel; the reserved code falls back to sequential.
  typedef enum logic [1:0] {
    ORD_SEQ  = 2'b00,
    ORD_WRAP = 2'b01,
    ORD_PAIR = 2'b10,
    ORD_RSVD = 2'b11
  } orderE;

  // Strobes from control to datapath, at most one high per cycle.
  typedef struct packed {
    logic loadStart;
    logic advance;
    logic finish;
  } ctrlStrobesT;

endpackage

// File: rtl/burst_order_dp.sv
module burst_order_dp
  import burst_order_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  localparam int OFS_W = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobesT      strobes,
  input  logic             active,
  input  logic [OFS_W-1:0] critOfs,
  input  logic [1:0]       orderSel,
  output logic [OFS_W-1:0] beatOfs,
  output logic             isLast
);

  localparam logic [OFS_W-1:0] LAST_IDX = OFS_W'(LINE_WORDS - 1);

  logic [OFS_W-1:0] critQ;
  logic [OFS_W-1:0] cntQ;
  orderE            orderQ;
  logic [OFS_W-1:0] rawOfs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      critQ  <= '0;
      cntQ   <= '0;
      orderQ <= ORD_SEQ;
    end else if (strobes.loadStart) begin
      critQ  <= critOfs;
      orderQ <= orderE'(orderSel);
      cntQ   <= '0;
    end else if (strobes.advance) begin
      cntQ <= cntQ + 1'b1;
    end else if (strobes.finish) begin
      cntQ <= '0;
    end
  end

  // Power-of-two line length: the adder wraps modulo the line by width.
  always_comb begin
    unique case (orderQ)
      ORD_WRAP: rawOfs = critQ + cntQ;
      ORD_PAIR: rawOfs = critQ ^ cntQ;
      default:  rawOfs = cntQ;
    endcase
  end

  assign beatOfs = active ? rawOfs : '0;
  assign isLast  = (cntQ == LAST_IDX);

endmodule

// File: rtl/burst_order_ctrl.sv
module burst_order_ctrl
  import burst_order_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        nextBeat,
  input  logic        isLast,
  output ctrlStrobesT strobes,
  output logic        active,
  output logic        lastBeat
);

  logic activeQ;

  always_comb begin
    strobes.loadStart = startPulse && !activeQ;
    strobes.advance   = nextBeat && activeQ && !isLast;
    strobes.finish    = nextBeat && activeQ && isLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  activeQ <= 1'b0;
    else if (strobes.loadStart) activeQ <= 1'b1;
    else if (strobes.finish)    activeQ <= 1'b0;
  end

  assign active   = activeQ;
  assign lastBeat = activeQ && isLast;

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
  import burst_order_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  localparam int OFS_W = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [OFS_W-1:0] critOfs,
  input  logic [1:0]       orderSel,
  input  logic             nextBeat,
  output logic [OFS_W-1:0] beatOfs,
  output logic             beatValid,
  output logic             lastBeat
);

  ctrlStrobesT strobes;
  logic        active;
  logic        isLast;

  burst_order_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .nextBeat   (nextBeat),
    .isLast     (isLast),
    .strobes    (strobes),
    .active     (active),
    .lastBeat   (lastBeat)
  );

  burst_order_dp #(.LINE_WORDS(LINE_WORDS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .active   (active),
    .critOfs  (critOfs),
    .orderSel (orderSel),
    .beatOfs  (beatOfs),
    .isLast   (isLast)
  );

  assign beatValid = active;

endmodule

// File: rtl/burst_order_chk.sv
module burst_order_chk #(
  parameter int LINE_WORDS = 4,
  localparam int OFS_W = $clog2(LINE_WORDS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic [OFS_W-1:0] critOfs,
  input logic [1:0]       orderSel,
  input logic             nextBeat,
  input logic [OFS_W-1:0] beatOfs,
  input logic             beatValid,
  input logic             lastBeat
);

  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!beatValid && startPulse) |=> (beatValid &&
      beatOfs == ((($past(orderSel) == 2'b00) || ($past(orderSel) == 2'b11)) ? '0 : $past(critOfs))));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !nextBeat) |=> (beatValid && $stable(beatOfs) && $stable(lastBeat)));

  p_last_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && nextBeat) |=> !beatValid);

  p_advance_stays_r8: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !lastBeat && nextBeat) |=> (beatValid && !$stable(beatOfs)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !beatValid |-> (beatOfs == '0 && !lastBeat));

  p_idle_next_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!beatValid && !startPulse) |=> !beatValid);

  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && startPulse && !nextBeat) |=> (beatValid && $stable(beatOfs)));

endmodule

bind burst_order_gen burst_order_chk #(.LINE_WORDS(LINE_WORDS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .critOfs    (critOfs),
  .orderSel   (orderSel),
  .nextBeat   (nextBeat),
  .beatOfs    (beatOfs),
  .beatValid  (beatValid),
  .lastBeat   (lastBeat)
);

// File: tb/test_burst_order_gen.sv
module test_burst_order_gen;

  localparam int W     = 4;
  localparam int OFS_W = $clog2(W);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startPulse = 1'b0;
  logic [OFS_W-1:0] critOfs = '0;
  logic [1:0]       orderSel = 2'b00;
  logic             nextBeat = 1'b0;
  logic [OFS_W-1:0] beatOfs;
  logic             beatValid;
  logic             lastBeat;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  burst_order_gen #(.LINE_WORDS(W)) i_burst_order_gen (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .critOfs(critOfs),
    .orderSel(orderSel), .nextBeat(nextBeat), .beatOfs(beatOfs),
    .beatValid(beatValid), .lastBeat(lastBeat)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Offset of beat k as the requirements define it (R3, R4, R5, R6).
  function automatic int expOfs(input int ord, input int crit, input int k);
    case (ord)
      1:       return (crit + k) % W;
      2:       return crit ^ k;
      default: return k;
    endcase
  endfunction

  task automatic checkIdle(input string req);
    chk(beatValid == 1'b0, req, int'(beatValid), 0);
    chk(lastBeat == 1'b0, req, int'(lastBeat), 0);
    chk(beatOfs == '0, req, int'(beatOfs), 0);
  endtask

  task automatic startBurst(input int crit, input int ord);
    critOfs    = OFS_W'(crit);
    orderSel   = 2'(ord);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  // Full burst: every beat offset, lastBeat placement, return to idle (R2, R8).
  task automatic runBurst(input int crit, input int ord, input string req);
    startBurst(crit, ord);
    for (int k = 0; k < W; k++) begin
      chk(beatValid == 1'b1, req, int'(beatValid), 1);
      chk(int'(beatOfs) == expOfs(ord, crit, k), req, int'(beatOfs), expOfs(ord, crit, k));
      chk(lastBeat == (k == W - 1), "R8", int'(lastBeat), int'(k == W - 1));
      nextBeat = 1'b1;
      @(negedge clk);
      nextBeat = 1'b0;
    end
    checkIdle("R8");
  endtask

  task automatic testReset();
    checkIdle("R1");
  endtask

  task automatic testSequential();
    for (int c = 0; c < W; c++) runBurst(c, 0, "R3");
  endtask

  task automatic testWrap();
    for (int c = 0; c < W; c++) runBurst(c, 1, "R4");
  endtask

  task automatic testPaired();
    for (int c = 0; c < W; c++) runBurst(c, 2, "R5");
  endtask

  task automatic testReserved();
    runBurst(2, 3, "R6");
  endtask

  task automatic testHold();
    startBurst(3, 1);
    chk(int'(beatOfs) == 3, "R2", int'(beatOfs), 3);
    nextBeat = 1'b1;
    @(negedge clk);
    nextBeat = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(beatValid == 1'b1 && int'(beatOfs) == 0, "R7", int'(beatOfs), 0);
    end
    for (int k = 2; k < W; k++) begin
      nextBeat = 1'b1;
      @(negedge clk);
    end
    chk(lastBeat == 1'b1, "R8", int'(lastBeat), 1);
    @(negedge clk);
    nextBeat = 1'b0;
    checkIdle("R8");
  endtask

  task automatic testIdleNext();
    nextBeat = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkIdle("R9");
    end
    nextBeat = 1'b0;
  endtask

  task automatic testBusyStart();
    startBurst(1, 1);
    nextBeat = 1'b1;
    @(negedge clk);
    nextBeat = 1'b0;
    chk(int'(beatOfs) == 2, "R10", int'(beatOfs), 2);
    critOfs    = OFS_W'(3);
    orderSel   = 2'b10;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk(beatValid == 1'b1 && int'(beatOfs) == 2, "R10", int'(beatOfs), 2);
    critOfs  = OFS_W'(0);
    orderSel = 2'b00;
    nextBeat = 1'b1;
    @(negedge clk);
    chk(int'(beatOfs) == 3, "R10", int'(beatOfs), 3);
    @(negedge clk);
    nextBeat = 1'b0;
    chk(int'(beatOfs) == 0 && lastBeat == 1'b1, "R10", int'(beatOfs), 0);
    nextBeat = 1'b1;
    @(negedge clk);
    nextBeat = 1'b0;
    checkIdle("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSequential();
    testWrap();
    testPaired();
    testReserved();
    testHold();
    testIdleNext();
    testBusyStart();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule